// File: doc/BRIEF.md
# I2C Command Pacing Gate

This block sits between a queue of pending transactions and an I2C controller engine, and decides in which cycle each transaction may start. It enforces the timing that a slow target device needs. A bus-free gap must follow every stop condition. At most two standard commands may start within any one-second sliding window. The result of a read-write standard command may only be read once a settle time has passed since that command. Multi-byte writes are cut into packets whose size depends on the configured SCL rate.

The requester holds `reqValid`, `reqKind` and `reqLen` stable until it sees `grant` together with `grantLast`. A write may need several packets, and the gate issues one grant for each. `grantBytes` tells the engine how many data bytes the granted packet carries. The engine pulses `busStop` when it puts a stop condition on the bus. A request that would break a limit is stalled, not dropped. Every time limit is a cycle count derived from the clock-frequency parameter.

Top module: `i2c_pace_gate`

## Requirements
- R1: After reset `grant` and `busy` are low. With no limit pending, a request is granted in the same cycle it is first presented.
- R2: After a grant, no further grant is issued until `busStop` has been seen.
- R3: After any `busStop` in cycle t, no grant is issued before cycle t+GapCyc. GapCyc is ceil(CLK_HZ*GAP_US/1e6), with a minimum of 1. When nothing else blocks the request, the grant comes exactly in cycle t+GapCyc.
- R4: When `sclKhz` > 100, every write packet (kinds 1 and 3) carries exactly one byte. A write of N>0 bytes takes N grants, and `grantLast` is set only on the last of them.
- R5: When `sclKhz` <= 100, write packets carry two bytes, and the final packet carries one byte if N is odd. A write of N bytes takes ceil(N/2) grants. A write with N=0 takes one grant with `grantBytes`=0.
- R6: A result read (kind 2) is not granted before cycle t+SettleCyc, where t is the cycle of the latest grant of a read-write command packet (kind 1). SettleCyc is SETTLE_MS milliseconds of clock cycles.
- R7: Standard commands are kind 0 (read-only) and the first packet of kind 1 (read-write). At most two of them are granted in any WinCyc-cycle window (WINDOW_MS milliseconds). A third one is granted no earlier than WinCyc cycles after the older of the two before it.
- R8: `grant` is never high while `reqValid` is low. A stalled request that stays valid is granted once its limits clear.
- R9: `busy` is high while the gap timer or the settle timer is running. That is the cycles t+1 .. t+GapCyc-1 after a stop in cycle t, and the cycles t+1 .. t+SettleCyc-1 after a kind 1 grant in cycle t.
- R10: Kind 3 (plain transfer) is neither counted against the window nor held by the settle timer.
- R11: Reads (kinds 0 and 2) are granted as one packet with `grantBytes`=0 and `grantLast`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A transaction is waiting; held until its last grant |
| reqKind | input | 2 | 0 read-only standard, 1 read-write standard write, 2 result read, 3 plain write |
| reqLen | input | LEN_W | Data bytes of a write |
| sclKhz | input | 10 | Configured SCL rate in kHz |
| busStop | input | 1 | Pulse: the engine put a stop condition on the bus |
| grant | output | 1 | The engine may start one packet in this cycle |
| grantBytes | output | LEN_W | Data bytes in the granted packet |
| grantLast | output | 1 | This grant ends the request |
| busy | output | 1 | Gap or settle timer running |

## Verification
Two limits can release in the same cycle. A gap can expire just as a window slot ages out, or just as the settle time ends. A packet can also be granted in the cycle an unexpected stop arrives. The bench provokes these with random stop delays and random idle times, which slide the stop events across the window and settle deadlines, and it adds unsolicited stops. A per-cycle model of the requirements judges each cycle. It expects a grant exactly in the first cycle in which every limit is open, and a grant in the same cycle as a stop must leave the packet in flight.

// File: rtl/i2c_pace_pkg.sv
package i2c_pace_pkg;

  typedef enum logic [1:0] {
    KIND_RO_STD = 2'd0,
    KIND_RW_STD = 2'd1,
    KIND_RESULT = 2'd2,
    KIND_PLAIN  = 2'd3
  } req_kind_e;

  // control -> datapath strobes
  typedef struct packed {
    logic grant;
    logic claimStd;
    logic armSettle;
  } pace_strobe_t;

  // cycles for `amount` units of 1/perSec seconds, rounded up, never below 1
  function automatic int unsigned toCycles(longint unsigned hz,
                                           longint unsigned amount,
                                           longint unsigned perSec);
    longint unsigned c;
    c = (hz * amount + perSec - 1) / perSec;
    if (c < 1) c = 1;
    return c[31:0];
  endfunction

endpackage

// File: rtl/i2c_pace_timers.sv
module i2c_pace_timers
  import i2c_pace_pkg::*;
#(
  parameter int unsigned GAP_CYC    = 66,
  parameter int unsigned SETTLE_CYC = 2000000,
  parameter int unsigned WIN_CYC    = 1000000,
  parameter int          STD_CAP    = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  pace_strobe_t strobe,
  input  logic         busStop,
  output logic         gapOpen,
  output logic         settleOpen,
  output logic         stdOpen,
  output logic         inFlight,
  output logic         busy
);

  localparam int unsigned MaxA   = (GAP_CYC > SETTLE_CYC) ? GAP_CYC : SETTLE_CYC;
  localparam int unsigned MaxCyc = (MaxA > WIN_CYC) ? MaxA : WIN_CYC;
  localparam int          CW     = $clog2(MaxCyc + 1);
  localparam logic [CW-1:0] GapLoad    = CW'(GAP_CYC - 1);
  localparam logic [CW-1:0] SettleLoad = CW'(SETTLE_CYC - 1);
  localparam logic [CW-1:0] WinLoad    = CW'(WIN_CYC - 1);

  logic [CW-1:0] gapCnt;
  logic [CW-1:0] settleCnt;
  logic [CW-1:0] slotCnt [STD_CAP];
  logic [STD_CAP-1:0] slotFree;
  logic [STD_CAP-1:0] slotClaim;

  // packet in flight: set by a grant, cleared by a stop; a grant wins
  always_ff @(posedge clk) begin
    if (!rstN)               inFlight <= 1'b0;
    else if (strobe.grant)   inFlight <= 1'b1;
    else if (busStop)        inFlight <= 1'b0;
  end

  // bus-free gap, restarted by every stop
  always_ff @(posedge clk) begin
    if (!rstN)                gapCnt <= '0;
    else if (busStop)         gapCnt <= GapLoad;
    else if (gapCnt != '0)    gapCnt <= gapCnt - 1'b1;
  end

  // settle time after a read-write command packet
  always_ff @(posedge clk) begin
    if (!rstN)                  settleCnt <= '0;
    else if (strobe.armSettle)  settleCnt <= SettleLoad;
    else if (settleCnt != '0)   settleCnt <= settleCnt - 1'b1;
  end

  // lowest free window slot takes a new standard command
  always_comb begin
    logic taken;
    taken     = 1'b0;
    slotClaim = '0;
    for (int i = 0; i < STD_CAP; i++) begin
      if (slotFree[i] && !taken) begin
        slotClaim[i] = strobe.claimStd;
        taken        = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < STD_CAP; g++) begin : gSlot
    assign slotFree[g] = (slotCnt[g] == '0);
    always_ff @(posedge clk) begin
      if (!rstN)                  slotCnt[g] <= '0;
      else if (slotClaim[g])      slotCnt[g] <= WinLoad;
      else if (slotCnt[g] != '0)  slotCnt[g] <= slotCnt[g] - 1'b1;
    end
  end

  assign gapOpen    = (gapCnt == '0);
  assign settleOpen = (settleCnt == '0);
  assign stdOpen    = |slotFree;
  assign busy       = (gapCnt != '0) || (settleCnt != '0);

endmodule

// File: rtl/i2c_pace_ctrl.sv
module i2c_pace_ctrl
  import i2c_pace_pkg::*;
#(
  parameter int LEN_W    = 4,
  parameter int FAST_KHZ = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [9:0]       sclKhz,
  input  logic             gapOpen,
  input  logic             settleOpen,
  input  logic             stdOpen,
  input  logic             inFlight,
  output pace_strobe_t     strobe,
  output logic [LEN_W-1:0] grantBytes,
  output logic             grantLast
);

  localparam logic [LEN_W-1:0] OneByte = LEN_W'(1);
  localparam logic [LEN_W-1:0] TwoByte = LEN_W'(2);

  req_kind_e        kind;
  logic [LEN_W-1:0] remBytes;
  logic [LEN_W-1:0] total;
  logic [LEN_W-1:0] chunkCap;
  logic [LEN_W-1:0] chunk;
  logic             firstPkt;
  logic             isWrite;
  logic             fastBus;
  logic             kindOk;
  logic             doGrant;

  assign kind     = req_kind_e'(reqKind);
  assign isWrite  = (kind == KIND_RW_STD) || (kind == KIND_PLAIN);
  assign firstPkt = (remBytes == '0);
  assign fastBus  = (sclKhz > 10'(FAST_KHZ));
  assign total    = firstPkt ? reqLen : remBytes;
  assign chunkCap = fastBus ? OneByte : TwoByte;
  assign chunk    = (total < chunkCap) ? total : chunkCap;

  always_comb begin
    unique case (kind)
      KIND_RO_STD: kindOk = stdOpen;
      KIND_RW_STD: kindOk = firstPkt ? stdOpen : 1'b1;
      KIND_RESULT: kindOk = settleOpen;
      default:     kindOk = 1'b1;
    endcase
  end

  assign doGrant = reqValid && !inFlight && gapOpen && kindOk;

  always_comb begin
    strobe.grant     = doGrant;
    strobe.claimStd  = doGrant && ((kind == KIND_RO_STD) ||
                                   ((kind == KIND_RW_STD) && firstPkt));
    strobe.armSettle = doGrant && (kind == KIND_RW_STD);
  end

  assign grantBytes = isWrite ? chunk : '0;
  assign grantLast  = isWrite ? (total == chunk) : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN)                   remBytes <= '0;
    else if (doGrant && isWrite) remBytes <= total - chunk;
  end

endmodule

// File: rtl/i2c_pace_gate.sv
module i2c_pace_gate
  import i2c_pace_pkg::*;
#(
  parameter longint unsigned CLK_HZ    = 1000000,
  parameter longint unsigned GAP_US    = 66,
  parameter longint unsigned SETTLE_MS = 2000,
  parameter longint unsigned WINDOW_MS = 1000,
  parameter int              STD_CAP   = 2,
  parameter int              LEN_W     = 4,
  parameter int              FAST_KHZ  = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  input  logic [LEN_W-1:0] reqLen,
  input  logic [9:0]       sclKhz,
  input  logic             busStop,
  output logic             grant,
  output logic [LEN_W-1:0] grantBytes,
  output logic             grantLast,
  output logic             busy
);

  localparam int unsigned GapCyc    = toCycles(CLK_HZ, GAP_US, 1000000);
  localparam int unsigned SettleCyc = toCycles(CLK_HZ, SETTLE_MS, 1000);
  localparam int unsigned WinCyc    = toCycles(CLK_HZ, WINDOW_MS, 1000);

  pace_strobe_t strobe;
  logic gapOpen;
  logic settleOpen;
  logic stdOpen;
  logic inFlight;

  i2c_pace_ctrl #(.LEN_W(LEN_W), .FAST_KHZ(FAST_KHZ)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqLen(reqLen), .sclKhz(sclKhz), .gapOpen(gapOpen),
    .settleOpen(settleOpen), .stdOpen(stdOpen), .inFlight(inFlight),
    .strobe(strobe), .grantBytes(grantBytes), .grantLast(grantLast)
  );

  i2c_pace_timers #(
    .GAP_CYC(GapCyc), .SETTLE_CYC(SettleCyc), .WIN_CYC(WinCyc), .STD_CAP(STD_CAP)
  ) u_timers (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busStop(busStop),
    .gapOpen(gapOpen), .settleOpen(settleOpen), .stdOpen(stdOpen),
    .inFlight(inFlight), .busy(busy)
  );

  assign grant = strobe.grant;

endmodule

// File: rtl/i2c_pace_gate_chk.sv
module i2c_pace_gate_chk #(
  parameter int          LEN_W     = 4,
  parameter int          FAST_KHZ  = 100,
  parameter int unsigned GAP_CYC   = 66,
  parameter int unsigned SETTLE_CYC = 2000000
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [1:0]       reqKind,
  input logic [9:0]       sclKhz,
  input logic             busStop,
  input logic             grant,
  input logic [LEN_W-1:0] grantBytes,
  input logic             grantLast,
  input logic             busy
);

  AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> reqValid); // R8
  AST_ONE_PACKET_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rstN)
    grant |=> !grant); // R2
  AST_STOP_STARTS_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (busStop && GAP_CYC > 1) |=> busy); // R9
  AST_RW_ARMS_SETTLE: assert property (@(posedge clk) disable iff (!rstN)
    (grant && reqKind == 2'd1 && SETTLE_CYC > 1) |=> busy); // R6
  AST_FAST_SINGLE_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    (grant && reqKind[0] && sclKhz > 10'(FAST_KHZ)) |-> grantBytes <= LEN_W'(1)); // R4
  AST_PACKET_MAX_TWO: assert property (@(posedge clk) disable iff (!rstN)
    grant |-> grantBytes <= LEN_W'(2)); // R5
  AST_READ_SINGLE_PACKET: assert property (@(posedge clk) disable iff (!rstN)
    (grant && !reqKind[0]) |-> (grantBytes == '0 && grantLast)); // R11

endmodule

bind i2c_pace_gate i2c_pace_gate_chk #(
  .LEN_W(LEN_W), .FAST_KHZ(FAST_KHZ), .GAP_CYC(GapCyc), .SETTLE_CYC(SettleCyc)
) u_chk (.*);

// File: tb/i2c_pace_gate_bench.sv
module i2c_pace_gate_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam longint GAP = 8;      // 2000 Hz * 4000 us
  localparam longint WIN = 2000;   // 1000 ms
  localparam longint SET = 4000;   // 2000 ms

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = 2'd0;
  logic [3:0] reqLen = 4'd0;
  logic [9:0] sclKhz = 10'd400;
  logic busStop = 1'b0;
  logic grant, grantLast, busy;
  logic [3:0] grantBytes;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_pace_gate #(.CLK_HZ(2000), .GAP_US(4000), .SETTLE_MS(2000), .WINDOW_MS(1000))
    u_i2c_pace_gate (.clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
      .reqLen(reqLen), .sclKhz(sclKhz), .busStop(busStop), .grant(grant),
      .grantBytes(grantBytes), .grantLast(grantLast), .busy(busy));

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  bit modelOn = 1'b0;
  bit extStops = 1'b0;
  longint cyc = 0;
  // model state
  longint mStop = -1000000, mStdA = -1000000, mStdB = -1000000, mRw = -1000000;
  bit mInFl = 1'b0;
  int mRem = 0;
  // handshake with stimulus
  bit grantSeen = 1'b0, lastSeen = 1'b0, busyAtGrant = 1'b0;
  int pktCnt = 0;
  longint firstGrantCyc = 0, lastGrantCyc = 0, startCyc = 0;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic string grantTag(bit inFl, bit gapOk, logic [1:0] k);
    if (!reqValid) return "R8";
    if (inFl) return "R2";
    if (!gapOk) return "R3";
    case (k)
      2'd2: return "R6";
      2'd3: return "R10";
      default: return "R7";
    endcase
  endfunction

  // per-cycle reference model, evaluated away from the clock edge
  always @(negedge clk) begin
    if (modelOn) begin
      bit gapOk, stdOk, kindOk, eGrant, isWr, fast, eLast, eBusy;
      int total, cap, eBytes;
      gapOk = (cyc - mStop) >= GAP;
      stdOk = (cyc - mStdA) >= WIN;
      case (reqKind)
        2'd0: kindOk = stdOk;
        2'd1: kindOk = (mRem != 0) ? 1'b1 : stdOk;
        2'd2: kindOk = (cyc - mRw) >= SET;
        default: kindOk = 1'b1;
      endcase
      eGrant = reqValid && !mInFl && gapOk && kindOk;
      isWr = reqKind[0];
      fast = sclKhz > 10'd100;
      total = (mRem != 0) ? mRem : int'(reqLen);
      cap = fast ? 1 : 2;
      eBytes = isWr ? ((total < cap) ? total : cap) : 0;
      eLast = isWr ? (total == eBytes) : 1'b1;
      eBusy = ((cyc - mStop) >= 1 && (cyc - mStop) < GAP) ||
              ((cyc - mRw) >= 1 && (cyc - mRw) < SET);
      check(grant === eGrant, grantTag(mInFl, gapOk, reqKind), "grant", grant, eGrant);
      check(busy === eBusy, "R9", "busy", busy, eBusy);
      if (eGrant && grant) begin
        check(grantBytes == 4'(eBytes), isWr ? (fast ? "R4" : "R5") : "R11",
              "grantBytes", grantBytes, eBytes);
        check(grantLast === eLast, isWr ? (fast ? "R4" : "R5") : "R11",
              "grantLast", grantLast, eLast);
      end
      if (eGrant) begin
        mInFl = 1'b1;
        mRem = isWr ? total - eBytes : 0;
        if (reqKind == 2'd0 || (reqKind == 2'd1 && total == int'(reqLen) && mRem + eBytes == int'(reqLen) && !midWrite)) begin
          mStdA = mStdB; mStdB = cyc;
        end
        if (reqKind == 2'd1) mRw = cyc;
        midWrite = isWr && (mRem != 0);
      end
      if (busStop) begin
        if (!eGrant) mInFl = 1'b0;
        mStop = cyc;
      end
      if (grant) begin
        if (pktCnt == 0) firstGrantCyc = cyc;
        pktCnt++;
        lastGrantCyc = cyc;
        busyAtGrant = busy;
        grantSeen = 1'b1;
        if (grantLast) lastSeen = 1'b1;
      end
      cyc++;
    end
  end
  bit midWrite = 1'b0;

  // target engine: stop after a short random delay, optional unsolicited stops
  initial begin
    int stopCnt;
    stopCnt = 0;
    forever begin
      @(posedge clk); #1;
      busStop = 1'b0;
      if (grantSeen) begin
        grantSeen = 1'b0;
        stopCnt = 1 + int'($urandom % 4);
      end else if (stopCnt > 0) begin
        stopCnt--;
        if (stopCnt == 0) busStop = 1'b1;
      end else if (extStops && ($urandom % 60) == 0) begin
        busStop = 1'b1;
      end
    end
  end

  task automatic issue(input logic [1:0] k, input int len, input int khz);
    @(posedge clk); #1;
    reqKind = k; reqLen = 4'(len); sclKhz = 10'(khz);
    pktCnt = 0; lastSeen = 1'b0; startCyc = cyc;
    reqValid = 1'b1;
    while (!lastSeen) begin @(posedge clk); #1; end
    reqValid = 1'b0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    longint t1, t3, tRw;
    void'($urandom(32'd20240611));
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    modelOn = 1'b1;
    @(negedge clk); #1;
    check(grant === 1'b0 && busy === 1'b0, "R1", "reset outputs", {grant, busy}, 0);

    // fast write: one byte per packet; first grant immediate
    issue(2'd3, 3, 400);
    check(firstGrantCyc == startCyc, "R1", "first grant cycle", firstGrantCyc, startCyc);
    check(pktCnt == 3, "R4", "packets for 3 bytes fast", pktCnt, 3);
    // slow write: two bytes per packet
    issue(2'd3, 3, 100);
    check(pktCnt == 2, "R5", "packets for 3 bytes slow", pktCnt, 2);
    issue(2'd3, 4, 50);
    check(pktCnt == 2, "R5", "packets for 4 bytes slow", pktCnt, 2);
    issue(2'd3, 2, 101);
    check(pktCnt == 2, "R4", "packets for 2 bytes at 101 kHz", pktCnt, 2);
    issue(2'd3, 0, 100);
    check(pktCnt == 1, "R5", "packets for empty write", pktCnt, 1);

    // three read-only standard commands: third waits for the window
    issue(2'd0, 0, 400); t1 = firstGrantCyc;
    issue(2'd0, 0, 400);
    issue(2'd0, 0, 400); t3 = firstGrantCyc;
    check(t3 - t1 == WIN, "R7", "third standard command spacing", t3 - t1, WIN);

    // read-write command then result read waits for settle
    issue(2'd1, 2, 400);
    check(pktCnt == 2, "R4", "read-write packets fast", pktCnt, 2);
    tRw = lastGrantCyc;
    issue(2'd2, 0, 400);
    check(firstGrantCyc - tRw == SET, "R6", "result read after settle", firstGrantCyc - tRw, SET);

    // plain write is not held by settle
    issue(2'd1, 1, 100);
    tRw = lastGrantCyc;
    issue(2'd3, 1, 100);
    check(busyAtGrant === 1'b1, "R10", "plain granted during settle", busyAtGrant, 1);
    check(firstGrantCyc - tRw < SET, "R10", "plain not delayed by settle", firstGrantCyc - tRw, SET - 1);

    // random phase
    extStops = 1'b1;
    for (int n = 0; n < 60; n++) begin
      int r, khzSel;
      logic [1:0] k;
      r = int'($urandom % 20);
      k = (r < 3) ? 2'd0 : (r < 5) ? 2'd1 : (r < 7) ? 2'd2 : 2'd3;
      khzSel = int'($urandom % 4);
      issue(k, int'($urandom % 6),
            (khzSel == 0) ? 50 : (khzSel == 1) ? 100 : (khzSel == 2) ? 101 : 400);
      repeat (int'($urandom % 6)) @(posedge clk);
    end
    extStops = 1'b0;
    repeat (20) @(posedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

endmodule